// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address front end of a synchronous burst memory. On each rising clock edge it looks at two active-low address strobes, one from a processor and one from a controller, and at three chip-select inputs. When a strobe is recognised and the chip is selected, it captures the full 17-bit word address. The two low bits of that address are the first beat of a four-beat burst. After that, each cycle with the active-low advance input asserted and no strobe moves the burst to its next beat.

The burst order is chosen at run time by the order input. In linear order the low bits are the start value plus the beat count, modulo four. In interleaved order they are the start value XOR the beat count. The upper bits never change inside a burst. A registered selected flag shows whether the last recognised strobe found the chip selected. A second registered flag shows which strobe loaded the current address. Every input is sampled on every edge. The block never stalls and has no back-pressure, so all its pins are plain control and status signals.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears `word_addr_o`, `sel_o` and `src_proc_o` to 0. Reset takes priority over any strobe in the same cycle.
- R2: The chip counts as selected when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A recognised strobe while selected loads `addr_i`. In the next cycle `word_addr_o` equals the loaded address and `sel_o`=1.
- R3: When both strobes are low and `ce1_n`=0, the processor strobe wins. `src_proc_o` is 1 after a processor load and 0 after a controller load.
- R4: The processor strobe is ignored while `ce1_n`=1. With the controller strobe high, that cycle leaves `sel_o` and `src_proc_o` unchanged, and `adv_n` acts as if no strobe were present.
- R5: A recognised strobe while the chip is not selected clears `sel_o`. It leaves `word_addr_o` and `src_proc_o` unchanged.
- R6: When no strobe is recognised and `adv_n`=0, the burst moves one beat.
- R7: With `order_ilv`=0, the low two bits are (start + beat) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R8: With `order_ilv`=1, the low two bits are start XOR beat. For example, start 2 gives 2, 3, 0, 1, and start 3 gives 3, 2.
- R9: `order_ilv` acts on `word_addr_o` in the same cycle, using the stored start and beat.
- R10: When no strobe is recognised and `adv_n`=1, the address holds. `word_addr_o[16:2]` never changes without a load. After four advances the burst wraps back to its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 17 | Word address offered with a strobe |
| strb_proc_n | input | 1 | Processor address strobe, active low, gated by `ce1_n` |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| word_addr_o | output | 17 | Current word address |
| sel_o | output | 1 | Registered selected flag |
| src_proc_o | output | 1 | 1 when the processor strobe loaded the current address |

## Verification
The bench targets several corner cases, each of which exposes a specific wrong design:
- **Wrap past beat three.** The bench runs linear bursts that wrap past beat three. A counter that carried into bit 2 would corrupt the upper address.
- **Interleaved order from an odd start.** The bench runs interleaved bursts from start values where XOR and addition give different results. A design that used one rule for both orders would fail here.
- **Both strobes at once.** It drives both strobes together. A design that favoured the controller would clear `src_proc_o`.
- **Processor strobe with `ce1_n` high.** It drives the processor strobe alone while `ce1_n` is high. A design that honoured the strobe would drop `sel_o` or fail to advance.
- **Reset and mode changes.** It also checks that reset beats a simultaneous strobe, and that an order change mid-burst shows up in the same cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // Per-cycle decision of the strobe arbiter.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_DESEL = 2'd3
  } seq_act_e;

endpackage

// File: rtl/bseq_strobe_arb.sv
module bseq_strobe_arb
  import bseq_pkg::*;
(
  input  logic     strb_proc_n,
  input  logic     strb_ctrl_n,
  input  logic     adv_n,
  input  logic     ce1_n,
  input  logic     ce2,
  input  logic     ce3_n,
  output seq_act_e act_o,
  output logic     from_proc_o
);

  logic chip_on;
  logic proc_seen;
  logic ctrl_seen;

  assign chip_on   = !ce1_n && ce2 && !ce3_n;
  // The processor strobe only counts while ce1_n is low.
  assign proc_seen = !strb_proc_n && !ce1_n;
  assign ctrl_seen = !strb_ctrl_n;

  // The processor wins whenever it is seen.
  assign from_proc_o = proc_seen;

  always_comb begin
    if (proc_seen || ctrl_seen) begin
      act_o = chip_on ? ACT_LOAD : ACT_DESEL;
    end else begin
      act_o = adv_n ? ACT_HOLD : ACT_STEP;
    end
  end

endmodule

// File: rtl/bseq_burst_ctr.sv
module bseq_burst_ctr
  import bseq_pkg::*;
#(
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_act_e      act_i,
  input  logic [BB-1:0] start_i,
  input  logic          ilv_i,
  output logic [BB-1:0] low_o
);

  logic [BB-1:0] start_q;
  logic [BB-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      case (act_i)
        ACT_LOAD: begin
          start_q <= start_i;
          beat_q  <= '0;
        end
        ACT_STEP: beat_q <= beat_q + 1'b1;
        default:  ;
      endcase
    end
  end

  // The order is applied at the output so that it takes effect at once.
  assign low_o = ilv_i ? (start_q ^ beat_q) : (start_q + beat_q);

endmodule

// File: rtl/bseq_addr_hold.sv
module bseq_addr_hold
  import bseq_pkg::*;
#(
  parameter int UW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_act_e      act_i,
  input  logic          from_proc_i,
  input  logic [UW-1:0] upper_i,
  output logic [UW-1:0] upper_o,
  output logic          sel_o,
  output logic          src_proc_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_o    <= '0;
      sel_o      <= 1'b0;
      src_proc_o <= 1'b0;
    end else begin
      case (act_i)
        ACT_LOAD: begin
          upper_o    <= upper_i;
          sel_o      <= 1'b1;
          src_proc_o <= from_proc_i;
        end
        ACT_DESEL: sel_o <= 1'b0;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int AW = 17,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          order_ilv,
  output logic [AW-1:0] word_addr_o,
  output logic          sel_o,
  output logic          src_proc_o
);

  localparam int UW = AW - BB;

  seq_act_e      act;
  logic          from_proc;
  logic [BB-1:0] low;
  logic [UW-1:0] upper;

  bseq_strobe_arb u_arb (
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .adv_n       (adv_n),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .ce3_n       (ce3_n),
    .act_o       (act),
    .from_proc_o (from_proc)
  );

  bseq_burst_ctr #(.BB(BB)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act),
    .start_i (addr_i[BB-1:0]),
    .ilv_i   (order_ilv),
    .low_o   (low)
  );

  bseq_addr_hold #(.UW(UW)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .act_i       (act),
    .from_proc_i (from_proc),
    .upper_i     (addr_i[AW-1:BB]),
    .upper_o     (upper),
    .sel_o       (sel_o),
    .src_proc_o  (src_proc_o)
  );

  assign word_addr_o = {upper, low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 17,
  parameter int BB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_i,
  input logic          strb_proc_n,
  input logic          strb_ctrl_n,
  input logic          adv_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          order_ilv,
  input logic [AW-1:0] word_addr_o,
  input logic          sel_o,
  input logic          src_proc_o
);

  logic chip_on;
  logic strobe;

  assign chip_on = !ce1_n && ce2 && !ce3_n;
  assign strobe  = (!strb_proc_n && !ce1_n) || !strb_ctrl_n;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (word_addr_o == '0 && !sel_o && !src_proc_o));

  a_r2_load_addr: assert property (@(posedge clk) disable iff (rst)
    (strobe && chip_on) |=> (word_addr_o == $past(addr_i) && sel_o));

  a_r3_proc_wins: assert property (@(posedge clk) disable iff (rst)
    (!strb_proc_n && !strb_ctrl_n && chip_on) |=> src_proc_o);

  a_r4_proc_gated: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && strb_ctrl_n) |=> ($stable(sel_o) && $stable(src_proc_o)));

  a_r5_deselect: assert property (@(posedge clk) disable iff (rst)
    (strobe && !chip_on) |=> (!sel_o && $stable(word_addr_o[AW-1:BB])));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe && adv_n) |=> ($stable(word_addr_o) || !$stable(order_ilv)));

  a_r10_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!strobe) |=> $stable(word_addr_o[AW-1:BB]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .BB(BB)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_i      (addr_i),
  .strb_proc_n (strb_proc_n),
  .strb_ctrl_n (strb_ctrl_n),
  .adv_n       (adv_n),
  .ce1_n       (ce1_n),
  .ce2         (ce2),
  .ce3_n       (ce3_n),
  .order_ilv   (order_ilv),
  .word_addr_o (word_addr_o),
  .sel_o       (sel_o),
  .src_proc_o  (src_proc_o)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;

  localparam int NV = 16;
  localparam int VW = 43;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] addr_i = '0;
  logic        strb_proc_n = 1'b1;
  logic        strb_ctrl_n = 1'b1;
  logic        adv_n = 1'b1;
  logic        ce1_n = 1'b1;
  logic        ce2 = 1'b0;
  logic        ce3_n = 1'b1;
  logic        order_ilv = 1'b0;
  logic [16:0] word_addr_o;
  logic        sel_o;
  logic        src_proc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq u_dut (
    .clk (clk), .rst (rst), .addr_i (addr_i),
    .strb_proc_n (strb_proc_n), .strb_ctrl_n (strb_ctrl_n), .adv_n (adv_n),
    .ce1_n (ce1_n), .ce2 (ce2), .ce3_n (ce3_n), .order_ilv (order_ilv),
    .word_addr_o (word_addr_o), .sel_o (sel_o), .src_proc_o (src_proc_o)
  );

  // Vector layout: p c adv ce1 ce2 ce3 ilv | addr | exp_addr | exp_sel exp_src
  function automatic logic [VW-1:0] mk(bit p, bit c, bit a, bit e1, bit e2, bit e3,
                                       bit m, logic [16:0] ad, logic [16:0] ex,
                                       bit s, bit r);
    return {p, c, a, e1, e2, e3, m, ad, ex, s, r};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mk(0,1,1,0,1,0,0,17'h1ABC5,17'h1ABC5,1,1), // R2 processor load
    mk(1,1,0,0,1,0,0,17'h00000,17'h1ABC6,1,1), // R6 R7
    mk(1,1,0,0,1,0,0,17'h00000,17'h1ABC7,1,1), // R7
    mk(1,1,0,0,1,0,0,17'h00000,17'h1ABC4,1,1), // R7 wraps low bits
    mk(1,1,0,0,1,0,0,17'h00000,17'h1ABC5,1,1), // R10 back to start
    mk(1,1,1,0,1,0,0,17'h00000,17'h1ABC5,1,1), // R10 hold
    mk(1,0,1,0,1,0,1,17'h00006,17'h00006,1,0), // R3 controller load
    mk(1,1,0,0,1,0,1,17'h00000,17'h00007,1,0), // R8
    mk(1,1,0,0,1,0,1,17'h00000,17'h00004,1,0), // R8
    mk(1,1,0,0,1,0,1,17'h00000,17'h00005,1,0), // R8
    mk(0,0,1,0,1,0,1,17'h12343,17'h12343,1,1), // R3 both strobes
    mk(0,1,1,1,1,0,1,17'h0FFFF,17'h12343,1,1), // R4 gated, hold
    mk(0,1,0,1,1,0,1,17'h0FFFF,17'h12342,1,1), // R4 gated, advance
    mk(1,0,1,0,0,0,1,17'h05555,17'h12342,0,1), // R5 deselect
    mk(1,0,1,0,1,0,0,17'h1FFFF,17'h1FFFF,1,0), // R2 reselect
    mk(1,1,0,0,1,0,0,17'h00000,17'h1FFFC,1,0)  // R10 upper fixed
  };

  function automatic string tag_of(int i);
    case (i)
      0, 14:         return "R2";
      1:             return "R6";
      2, 3:          return "R7";
      7, 8, 9:       return "R8";
      6, 10:         return "R3";
      11, 12:        return "R4";
      13:            return "R5";
      default:       return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [16:0] ea, bit es, bit er);
    checks++;
    if (word_addr_o !== ea || sel_o !== es || src_proc_o !== er) begin
      errors++;
      $display("FAIL %s addr=%h exp=%h sel=%b exp=%b src=%b exp=%b",
               req, word_addr_o, ea, sel_o, es, src_proc_o, er);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset with a processor strobe present.
    strb_proc_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    addr_i = 17'h0AAAA;
    repeat (2) @(negedge clk);
    chk("R1", 17'h00000, 1'b0, 1'b0);
    strb_proc_n = 1'b1;

    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {strb_proc_n, strb_ctrl_n, adv_n, ce1_n, ce2, ce3_n, order_ilv, addr_i}
        = VEC[i][VW-1:19];
      @(negedge clk);
      chk(tag_of(i), VEC[i][18:2], VEC[i][1], VEC[i][0]);
    end

    // R9: order flips mid-burst (start 3, beat 1), seen in the same cycle.
    adv_n = 1'b1;
    order_ilv = 1'b1;
    #1;
    chk("R9", 17'h1FFFE, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10", 17'h1FFFE, 1'b1, 1'b0);

    // R1: reset beats a simultaneous strobe, then R2 once released.
    rst = 1'b1;
    strb_proc_n = 1'b0;
    addr_i = 17'h0AAAA;
    @(negedge clk);
    chk("R1", 17'h00000, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", 17'h0AAAA, 1'b1, 1'b1);

    // R5: deselect through ce3_n, address kept.
    strb_proc_n = 1'b1;
    strb_ctrl_n = 1'b0;
    ce3_n = 1'b1;
    addr_i = 17'h00001;
    @(negedge clk);
    chk("R5", 17'h0AAAA, 1'b0, 1'b1);

    finish_run();
  end

endmodule